// File: doc/BRIEF.md
# I2C Serial EEPROM Responder

This block is the device side of a byte-wide serial EEPROM, as seen from an I2C bus master. It runs on a fast system clock and oversamples the bus clock and data lines through synchronizers. All protocol decisions are made on edges of the synchronized values. The block never drives the data line high. It only asserts an active-low pull enable, which the pad or bench combines with the bus as an open-drain wired-AND.

A master stores one byte with this sequence: START, a write control byte, two word-address bytes, one data byte, STOP. To read one byte, the master first sends a dummy write that carries only the address. It then issues a repeated START and a read control byte, clocks in one data byte, answers with a no-acknowledge, and ends with STOP. A write-protect pin stops bytes from being stored. Three strap pins select the chip address. A one-cycle pulse marks each transfer that completed correctly.

Top module: `serial_eeprom_responder`

## Requirements
- R1: A START (SDA falls while SCL is high) sends the responder to control-byte reception from any state. A STOP (SDA rises while SCL is high) sends it to idle, and it releases SDA (sda_oe_o=0) within one cycle of detecting the STOP.
- R2: The control byte is received MSB first. It is accepted only when its upper seven bits equal 1010 followed by strap_i[2:0] (strap_i[2] first). Bit 0 selects the direction: 0 is write and 1 is read. On a mismatch the byte gets no acknowledge, and the responder ignores the bus until the next START.
- R3: For each accepted byte (control, address high, address low, data), the responder pulls SDA low for the whole ninth SCL high phase.
- R4: For a write sequence, the data byte is stored at the addressed location when the STOP that follows it arrives.
- R5: The word address is two bytes, high byte first. Only the low ADDR_W bits (12 by default) select the location, and the upper bits have no effect.
- R6: In a random read, after the read control byte is acknowledged, the responder drives the addressed byte MSB first. It changes each bit only while SCL is low, and it releases SDA for the master's ninth (acknowledge) clock.
- R7: While wp_i is high at the closing STOP, the write leaves the array unchanged. Reads work as normal.
- R8: A START that arrives after the data byte but before the STOP discards the pending write.
- R9: xfer_done_o pulses for exactly one cycle after the STOP that ends a stored-or-protected write, or a read that the master closed with a no-acknowledge. An aborted or rejected transfer gives no pulse.
- R10: After reset, every array location reads as 0x00.
- R11: SDA stays released after reset and whenever the responder is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level (wired-AND result) |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |
| wp_i | input | 1 | Write protect, 1 blocks storage |
| strap_i | input | 3 | Chip address straps |
| xfer_done_o | output | 1 | One-cycle transfer-complete pulse |

## Verification
The bench builds the responder with ADDR_W=12 and SYNC_STAGES=2. The full 4096-entry array and the ignored top four address bits are therefore exercised directly. The straps are tied to a non-zero pattern, so a plain 0xA0 control byte is a realistic wrong-address case. A quarter SCL period of ten system clocks leaves room for the synchronizer delay before each bit is sampled. It also keeps all of the random traffic, plus the abort, protect and mismatch cases, within a short run.

// File: rtl/eep_pkg.sv
package eep_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_RX, ST_ACK, ST_TX, ST_TXACK
  } eep_state_t;

  typedef enum logic [2:0] {
    PH_CTRL, PH_AHI, PH_ALO, PH_DATA, PH_XTRA
  } eep_phase_t;

  localparam logic [3:0] DEV_TYPE = 4'b1010;
endpackage

// File: rtl/eep_line_sync.sv
module eep_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic level_o,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] pipe;
  logic              prev;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) pipe <= '1;
        else        pipe <= line_i;
    end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) pipe <= '1;
        else        pipe <= {pipe[STAGES-2:0], line_i};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prev <= 1'b1;
    else        prev <= pipe[STAGES-1];

  assign level_o = pipe[STAGES-1];
  assign rise_o  = pipe[STAGES-1] & ~prev;
  assign fall_o  = ~pipe[STAGES-1] & prev;
endmodule

// File: rtl/eep_mem.sv
module eep_mem #(
  parameter int AW = 12,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] cells [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) cells[i] <= '0;
    end else if (we) begin
      cells[addr] <= wdata;
    end
  end

  assign rdata = cells[addr];
endmodule

// File: rtl/eep_bus_fsm.sv
module eep_bus_fsm
  import eep_pkg::*;
#(
  parameter int AW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_lvl,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          sda_lvl,
  input  logic          sda_rise,
  input  logic          sda_fall,
  input  logic          wp,
  input  logic [2:0]    strap,
  input  logic [7:0]    mem_rdata,
  output logic [AW-1:0] mem_addr,
  output logic [7:0]    mem_wdata,
  output logic          mem_we,
  output logic          sda_oe,
  output logic          xfer_done,
  output logic          start_det,
  output logic          stop_det,
  output eep_state_t    state
);
  eep_phase_t  phase;
  logic [7:0]  shreg;
  logic [7:0]  txreg;
  logic [3:0]  bitcnt;
  logic [AW-1:0] addr_q;
  logic        to_tx;
  logic        pend_wr;
  logic        rd_ok;

  assign start_det = scl_lvl & sda_fall;
  assign stop_det  = scl_lvl & sda_rise;
  assign mem_addr  = addr_q;
  assign mem_we    = stop_det & pend_wr & ~wp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      phase     <= PH_CTRL;
      shreg     <= '0;
      txreg     <= '0;
      bitcnt    <= '0;
      addr_q    <= '0;
      mem_wdata <= '0;
      to_tx     <= 1'b0;
      pend_wr   <= 1'b0;
      rd_ok     <= 1'b0;
      sda_oe    <= 1'b0;
      xfer_done <= 1'b0;
    end else begin
      xfer_done <= stop_det & (pend_wr | rd_ok);
      if (stop_det) begin
        state   <= ST_IDLE;
        sda_oe  <= 1'b0;
        pend_wr <= 1'b0;
        rd_ok   <= 1'b0;
      end else if (start_det) begin
        state   <= ST_RX;
        phase   <= PH_CTRL;
        bitcnt  <= '0;
        sda_oe  <= 1'b0;
        pend_wr <= 1'b0;
        rd_ok   <= 1'b0;
      end else begin
        unique case (state)
          ST_RX: begin
            if (scl_rise && bitcnt < 4'd8) begin
              shreg  <= {shreg[6:0], sda_lvl};
              bitcnt <= bitcnt + 4'd1;
            end else if (scl_fall && bitcnt == 4'd8) begin
              to_tx <= 1'b0;
              unique case (phase)
                PH_CTRL: begin
                  if (shreg[7:1] == {DEV_TYPE, strap}) begin
                    sda_oe <= 1'b1;
                    state  <= ST_ACK;
                    to_tx  <= shreg[0];
                    phase  <= PH_AHI;
                  end else begin
                    state <= ST_IDLE;
                  end
                end
                PH_AHI, PH_ALO: begin
                  addr_q <= {addr_q[AW-9:0], shreg};
                  sda_oe <= 1'b1;
                  state  <= ST_ACK;
                  phase  <= (phase == PH_AHI) ? PH_ALO : PH_DATA;
                end
                PH_DATA: begin
                  mem_wdata <= shreg;
                  pend_wr   <= 1'b1;
                  sda_oe    <= 1'b1;
                  state     <= ST_ACK;
                  phase     <= PH_XTRA;
                end
                default: state <= ST_IDLE;
              endcase
            end
          end
          ST_ACK: begin
            if (scl_fall) begin
              bitcnt <= '0;
              if (to_tx) begin
                txreg  <= mem_rdata;
                sda_oe <= ~mem_rdata[7];
                state  <= ST_TX;
              end else begin
                sda_oe <= 1'b0;
                state  <= ST_RX;
              end
            end
          end
          ST_TX: begin
            if (scl_fall) begin
              if (bitcnt == 4'd7) begin
                sda_oe <= 1'b0;
                state  <= ST_TXACK;
              end else begin
                txreg  <= {txreg[6:0], 1'b0};
                sda_oe <= ~txreg[6];
                bitcnt <= bitcnt + 4'd1;
              end
            end
          end
          ST_TXACK: begin
            if (scl_rise) begin
              rd_ok <= sda_lvl;
              state <= ST_IDLE;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/serial_eeprom_responder.sv
module serial_eeprom_responder
  import eep_pkg::*;
#(
  parameter int ADDR_W      = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe_o,
  input  logic       wp_i,
  input  logic [2:0] strap_i,
  output logic       xfer_done_o
);
  logic scl_lvl, scl_rise, scl_fall;
  logic sda_lvl, sda_rise, sda_fall;
  logic [ADDR_W-1:0] mem_addr;
  logic [7:0]        mem_wdata, mem_rdata;
  logic              mem_we;
  logic              start_det, stop_det;
  eep_state_t        fsm_state;

  eep_line_sync #(.STAGES(SYNC_STAGES)) u_scl_sync (
    .clk(clk), .rst_n(rst_n), .line_i(scl_i),
    .level_o(scl_lvl), .rise_o(scl_rise), .fall_o(scl_fall));

  eep_line_sync #(.STAGES(SYNC_STAGES)) u_sda_sync (
    .clk(clk), .rst_n(rst_n), .line_i(sda_i),
    .level_o(sda_lvl), .rise_o(sda_rise), .fall_o(sda_fall));

  eep_bus_fsm #(.AW(ADDR_W)) u_fsm (
    .clk(clk), .rst_n(rst_n),
    .scl_lvl(scl_lvl), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .sda_lvl(sda_lvl), .sda_rise(sda_rise), .sda_fall(sda_fall),
    .wp(wp_i), .strap(strap_i), .mem_rdata(mem_rdata),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
    .sda_oe(sda_oe_o), .xfer_done(xfer_done_o),
    .start_det(start_det), .stop_det(stop_det), .state(fsm_state));

  eep_mem #(.AW(ADDR_W), .DW(8)) u_mem (
    .clk(clk), .rst_n(rst_n), .we(mem_we), .addr(mem_addr),
    .wdata(mem_wdata), .rdata(mem_rdata));
endmodule

// File: rtl/eep_responder_checker.sv
module eep_responder_checker
  import eep_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       sda_oe,
  input logic       xfer_done,
  input logic       start_det,
  input logic       stop_det,
  input eep_state_t state,
  input logic       mem_we,
  input logic       wp
);
  assert_stop_releases_R1: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (!sda_oe && state == ST_IDLE));

  assert_start_restarts_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (start_det && !stop_det) |=> (!sda_oe && state == ST_RX));

  assert_drive_only_in_slots_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> (state == ST_ACK || state == ST_TX));

  assert_idle_released_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE) |-> !sda_oe);

  assert_protect_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> !wp);

  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |=> !xfer_done);

  assert_done_after_stop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |-> $past(stop_det));
endmodule

bind serial_eeprom_responder eep_responder_checker u_chk (
  .clk(clk), .rst_n(rst_n), .sda_oe(sda_oe_o), .xfer_done(xfer_done_o),
  .start_det(start_det), .stop_det(stop_det), .state(fsm_state),
  .mem_we(mem_we), .wp(wp_i));

// File: tb/tb_serial_eeprom_responder.sv
module tb_serial_eeprom_responder;
  localparam int Q = 10;
  localparam logic [2:0] STRAP = 3'b101;
  localparam logic [7:0] CW = {4'b1010, STRAP, 1'b0};
  localparam logic [7:0] CR = {4'b1010, STRAP, 1'b1};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1, wp = 1'b0;
  logic sda_oe, done;
  wire  sda_bus = sda_m & ~sda_oe;

  int checks = 0, failures = 0, done_cnt = 0;
  bit finished = 0;
  logic [7:0] model [4096];

  always #2 clk = ~clk;

  serial_eeprom_responder #(.ADDR_W(12), .SYNC_STAGES(2)) dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
    .sda_oe_o(sda_oe), .wp_i(wp), .strap_i(STRAP), .xfer_done_o(done));

  always @(posedge clk) if (rst_n && done) done_cnt <= done_cnt + 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n); repeat (n) @(negedge clk); endtask

  task automatic bus_start;
    sda_m = 1; tick(Q); scl_m = 1; tick(Q); sda_m = 0; tick(Q); scl_m = 0; tick(Q);
  endtask
  task automatic bus_stop;
    sda_m = 0; tick(Q); scl_m = 1; tick(Q); sda_m = 1; tick(2*Q);
  endtask
  task automatic put_bit(input logic b);
    sda_m = b; tick(Q); scl_m = 1; tick(2*Q); scl_m = 0; tick(Q);
  endtask
  task automatic get_bit(output logic b);
    sda_m = 1; tick(Q); scl_m = 1; tick(Q); b = sda_bus; tick(Q); scl_m = 0; tick(Q);
  endtask
  task automatic put_byte(input logic [7:0] d, output logic ack);
    for (int i = 7; i >= 0; i--) put_bit(d[i]);
    get_bit(ack);
  endtask
  task automatic get_byte(output logic [7:0] d, input logic nack);
    for (int i = 7; i >= 0; i--) get_bit(d[i]);
    put_bit(nack);
  endtask

  function automatic int eff(input logic [15:0] a); return int'(a[11:0]); endfunction

  task automatic do_write(input logic [15:0] a, input logic [7:0] d, output logic nak);
    logic a0, a1, a2, a3;
    bus_start;
    put_byte(CW, a0); put_byte(a[15:8], a1); put_byte(a[7:0], a2); put_byte(d, a3);
    bus_stop;
    nak = a0 | a1 | a2 | a3;
  endtask

  task automatic do_read(input logic [15:0] a, output logic [7:0] d, output logic nak);
    logic a0, a1, a2, a3;
    bus_start;
    put_byte(CW, a0); put_byte(a[15:8], a1); put_byte(a[7:0], a2);
    bus_start;
    put_byte(CR, a3);
    get_byte(d, 1'b1);
    bus_stop;
    nak = a0 | a1 | a2 | a3;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd;
    logic nak, ack;
    int dc;
    void'($urandom(32'h5EED_0042));
    for (int i = 0; i < 4096; i++) model[i] = 8'h00;
    tick(5);
    // R11 / R9: reset state
    check(sda_oe == 0, "R11 reset release", int'(sda_oe), 0);
    check(done == 0, "R9 reset done low", int'(done), 0);
    rst_n = 1; tick(5);

    // R10: unwritten location is zero; R3 acks
    dc = done_cnt;
    do_read(16'h0123, rd, nak);
    check(nak == 0, "R3 read acks", int'(nak), 0);
    check(rd == 8'h00, "R10 zero after reset", int'(rd), 0);
    check(done_cnt == dc + 1, "R9 read done pulse", done_cnt - dc, 1);

    // R4 / R6: directed write and read back
    dc = done_cnt;
    do_write(16'h0ABC, 8'h5A, nak); model[eff(16'h0ABC)] = 8'h5A;
    check(nak == 0, "R3 write acks", int'(nak), 0);
    check(done_cnt == dc + 1, "R9 write done pulse", done_cnt - dc, 1);
    do_read(16'h0ABC, rd, nak);
    check(rd == 8'h5A, "R4 R6 directed readback", int'(rd), 'h5A);

    // R5: upper address bits ignored
    do_write(16'hF7FF, 8'h3C, nak); model[eff(16'hF7FF)] = 8'h3C;
    do_read(16'h07FF, rd, nak);
    check(rd == 8'h3C, "R5 upper bits ignored", int'(rd), 'h3C);

    // R2: mismatched control byte not acknowledged
    bus_start;
    put_byte(8'hA0, ack);
    check(ack == 1, "R2 mismatch no ack", int'(ack), 1);
    put_byte(8'h0A, ack);
    check(ack == 1 && sda_oe == 0, "R2 ignored after mismatch", int'(ack), 1);
    bus_stop;
    check(sda_oe == 0, "R1 stop releases", int'(sda_oe), 0);

    // R7: write protect
    dc = done_cnt;
    wp = 1;
    do_write(16'h0100, 8'hEE, nak);
    do_read(16'h0100, rd, nak);
    check(rd == model[eff(16'h0100)], "R7 protected write", int'(rd), int'(model[eff(16'h0100)]));
    check(nak == 0, "R7 read under protect", int'(nak), 0);
    wp = 0;

    // R8: START after data byte aborts the write
    dc = done_cnt;
    bus_start;
    put_byte(CW, ack); put_byte(8'h0A, ack); put_byte(8'hBC, ack); put_byte(8'hC3, ack);
    bus_start;
    check(sda_oe == 0, "R1 start releases", int'(sda_oe), 0);
    bus_stop;
    check(done_cnt == dc, "R9 no pulse on abort", done_cnt - dc, 0);
    do_read(16'h0ABC, rd, nak);
    check(rd == 8'h5A, "R8 aborted write discarded", int'(rd), 'h5A);

    // Random traffic: R4 R5 R6
    for (int n = 0; n < 24; n++) begin
      logic [15:0] a = 16'($urandom);
      logic [7:0]  d = 8'($urandom);
      logic [15:0] b;
      do_write(a, d, nak); model[eff(a)] = d;
      b = {4'($urandom), a[11:0]};
      do_read(b, rd, nak);
      check(rd == model[eff(b)] && nak == 0, "R4 R6 random readback", int'(rd), int'(model[eff(b)]));
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule